// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Commits

The block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day, month, year) and advances them on a single-cycle one-second tick input. The tick is already in the bus clock domain. Software sees three 32-bit registers on a simple register bus: a packed time word, a packed date word and a status word. Reads return the live counters. The date word carries an explicit leap flag, and that flag sets the length of February.

A software write does not change the counters at once. The written word is held in a shadow register, and a busy flag for that register goes high. The live counters keep running. On the second slow tick after the write, the shadow value is loaded and the flag drops. Software polls the busy flags before it starts another update. Any write to a register whose flag is still set is dropped.

The year is held as a 6-bit offset from 1970, so the range is 1970 through 2033. After the last second of offset 63, the counters wrap to offset 0.

Top module: `cal_keeper`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, offset 0, leap 0), and the status word reads 0.
- R2: The time word at offset 0x14 returns the live counters, with seconds in [5:0], minutes in [13:8] and hours in [20:16]. All other bits read 0.
- R3: The date word at offset 0x10 returns the live counters, with day in [4:0], month in [11:8] (1 to 12), year offset in [21:16] and leap in bit 22. All other bits read 0.
- R4: An accepted time write sets status bit 8, and an accepted date write sets status bit 7, both visible from the next cycle. Status bit 9 and all other status bits read 0.
- R5: A pending value is loaded into the counters on the second tick after its write, and its flag clears at that same edge. A tick in the same cycle as the write is not counted.
- R6: A write to the time or date word while its own flag is set has no effect, including a write in the cycle of its commit.
- R7: Seconds and minutes roll over from 59 to 0, and hours roll over from 23 to 0. Each rollover carries into the next field.
- R8: A rollover from 23:59:59 advances the day. Past the month length the day becomes 1 and the month advances. The month length is 30 for months 4, 6, 9 and 11, 31 for the other months except February, and for February 29 when leap is 1 and 28 when leap is 0.
- R9: On a rollover past December 31, the year offset increments, wrapping from 63 to 0. Leap is then set to ((offset + 1970) mod 4 == 0).
- R10: The counters keep advancing while a write is pending. On the commit tick, the committed value replaces the advance of that register, and a committed date takes precedence over a day carry in the same cycle.
- R11: Writes to the status word or to any other offset change neither the counters nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |

## Verification
Two functions can fall in the same cycle. A deferred commit and the normal advance of the same counters can land on one edge, and so can a pending date load and the day carry from 23:59:59. The bench provokes both on purpose: it commits a time of 23:59:58 first, then writes a date so that its second tick is the one that rolls the clock over. The bench checks that the written date wins and the time still wraps to zero. Random runs also mix ticks and writes that collide with commit edges. A reference model judges every cycle, and that model is built from the commit and rollover rules alone.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 6;
  localparam int WORD_W = 32;

  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_DATE = 8'h10;
  localparam logic [7:0] ADDR_TIME = 8'h14;
  localparam int BIT_DATE_BUSY = 7;
  localparam int BIT_TIME_BUSY = 8;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } clk_time_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
  } clk_date_t;

  function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] mon, logic leap);
    case (mon)
      4'd2:                       return leap ? DAY_W'(29) : DAY_W'(28);
      4'd4, 4'd6, 4'd9, 4'd11:    return DAY_W'(30);
      default:                    return DAY_W'(31);
    endcase
  endfunction

  // base year 1970 is 2 mod 4
  function automatic logic leap_of(logic [YR_W-1:0] yr);
    return yr[1:0] == 2'd2;
  endfunction

  function automatic clk_time_t unpack_time(logic [WORD_W-1:0] w);
    clk_time_t t;
    t.sec = w[5:0];
    t.min = w[13:8];
    t.hr  = w[20:16];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] pack_time(clk_time_t t);
    logic [WORD_W-1:0] w;
    w = '0;
    w[5:0]   = t.sec;
    w[13:8]  = t.min;
    w[20:16] = t.hr;
    return w;
  endfunction

  function automatic clk_date_t unpack_date(logic [WORD_W-1:0] w);
    clk_date_t d;
    d.day  = w[4:0];
    d.mon  = w[11:8];
    d.yr   = w[21:16];
    d.leap = w[22];
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] pack_date(clk_date_t d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[4:0]   = d.day;
    w[11:8]  = d.mon;
    w[21:16] = d.yr;
    w[22]    = d.leap;
    return w;
  endfunction
endpackage

// File: rtl/cal_commit.sv
module cal_commit #(
  parameter int W     = 32,
  parameter int TICKS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         commit_o,
  output logic [W-1:0] value_o
);
  localparam int CNT_W = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     shadow_q;

  assign commit_o = pend_q & tick_i & (cnt_q == LAST);
  assign busy_o   = pend_q;
  assign value_o  = shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (commit_o) begin
      pend_q <= 1'b0;
    end else if (wr_i && !pend_q) begin
      pend_q   <= 1'b1;
      cnt_q    <= '0;
      shadow_q <= wdata_i;
    end else if (pend_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !pend_q |=> pend_q && shadow_q == $past(wdata_i));
  assert_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && pend_q |=> shadow_q == $past(shadow_q));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !pend_q);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !tick_i |=> pend_q && $stable(cnt_q));
endmodule

// File: rtl/cal_time_ctr.sv
module cal_time_ctr
  import cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  clk_time_t load_val_i,
  output clk_time_t time_o,
  output logic      day_carry_o
);
  clk_time_t q, nxt;
  logic sec_wrap, min_wrap, hr_wrap;

  assign sec_wrap = q.sec >= SEC_W'(59);
  assign min_wrap = q.min >= MIN_W'(59);
  assign hr_wrap  = q.hr  >= HR_W'(23);

  always_comb begin
    nxt = q;
    if (!sec_wrap) begin
      nxt.sec = q.sec + 1'b1;
    end else begin
      nxt.sec = '0;
      if (!min_wrap) begin
        nxt.min = q.min + 1'b1;
      end else begin
        nxt.min = '0;
        nxt.hr  = hr_wrap ? '0 : q.hr + 1'b1;
      end
    end
  end

  assign day_carry_o = tick_i & ~load_i & sec_wrap & min_wrap & hr_wrap;
  assign time_o      = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= load_val_i;
    else if (tick_i) q <= nxt;
  end

  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_o == $past(load_val_i));
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(time_o));
  assert_midnight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |=> time_o == '0);
endmodule

// File: rtl/cal_date_ctr.sv
module cal_date_ctr
  import cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      load_i,
  input  clk_date_t load_val_i,
  output clk_date_t date_o
);
  clk_date_t q, nxt;
  logic [DAY_W-1:0] mlen;
  logic [YR_W-1:0]  yr_inc;

  assign mlen   = month_len(q.mon, q.leap);
  assign yr_inc = q.yr + 1'b1;

  always_comb begin
    nxt = q;
    if (q.day < mlen) begin
      nxt.day = q.day + 1'b1;
    end else begin
      nxt.day = DAY_W'(1);
      if (q.mon < MON_W'(12)) begin
        nxt.mon = q.mon + 1'b1;
      end else begin
        nxt.mon  = MON_W'(1);
        nxt.yr   = yr_inc;
        nxt.leap = leap_of(yr_inc);
      end
    end
  end

  assign date_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      q.day  <= DAY_W'(1);
      q.mon  <= MON_W'(1);
    end else if (load_i) begin
      q <= load_val_i;
    end else if (adv_i) begin
      q <= nxt;
    end
  end

  assert_dload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> date_o == $past(load_val_i));
  assert_feb_leap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && q.mon == 4'd2 && q.day == 5'd28 && q.leap |=> date_o.day == 5'd29);
  assert_era_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && q.yr == 6'd63 && q.mon == 4'd12 && q.day == 5'd31
    |=> date_o.yr == '0 && date_o.mon == 4'd1 && date_o.day == 5'd1 && !date_o.leap);
  assert_dstable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !load_i |=> $stable(date_o));
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
  import cal_pkg::*;
#(
  parameter int COMMIT_TICKS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int NREG = 2;  // 0: time, 1: date

  logic [NREG-1:0]        wr, busy, commit;
  logic [WORD_W-1:0]      value [NREG];
  logic [7:0]             reg_addr [NREG];
  clk_time_t              cur_time;
  clk_date_t              cur_date;
  logic                   day_carry;

  assign reg_addr[0] = ADDR_TIME;
  assign reg_addr[1] = ADDR_DATE;

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    assign wr[k] = req_i & we_i & (addr_i == reg_addr[k]);
    cal_commit #(.W(WORD_W), .TICKS(COMMIT_TICKS)) u_commit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .wr_i     (wr[k]),
      .wdata_i  (wdata_i),
      .busy_o   (busy[k]),
      .commit_o (commit[k]),
      .value_o  (value[k])
    );
  end

  cal_time_ctr u_time (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .load_i      (commit[0]),
    .load_val_i  (unpack_time(value[0])),
    .time_o      (cur_time),
    .day_carry_o (day_carry)
  );

  cal_date_ctr u_date (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (day_carry),
    .load_i     (commit[1]),
    .load_val_i (unpack_date(value[1])),
    .date_o     (cur_date)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_TIME: rdata_o = pack_time(cur_time);
      ADDR_DATE: rdata_o = pack_date(cur_date);
      ADDR_CTRL: begin
        rdata_o[BIT_TIME_BUSY] = busy[0];
        rdata_o[BIT_DATE_BUSY] = busy[1];
      end
      default:   rdata_o = '0;
    endcase
  end

  assert_ctrl_nochange_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == ADDR_CTRL && !tick_i |=> $stable(busy) && $stable(cur_time));
  assert_set_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr[0] && !busy[0] |=> busy[0]);
endmodule

// File: tb/cal_keeper_bench.sv
`timescale 1ns/1ps
module cal_keeper_bench;
  localparam int COMMIT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_keeper #(.COMMIT_TICKS(COMMIT)) u_cal_keeper (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // reference model state
  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 1, m_mon = 1, m_yr = 0;
  bit m_leap = 0;
  bit p_t = 0, p_d = 0;
  int c_t = 0, c_d = 0;
  logic [31:0] s_t = '0, s_d = '0;

  function automatic logic [31:0] mk_time(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] mk_date(int y, int mo, int d, bit l);
    return (32'(l) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  function automatic int days_in(int mo, bit l);
    if (mo == 2) return l ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic step(bit tk, bit rq, bit w, logic [7:0] a, logic [31:0] d);
    bit ct, cd, carry, wt, wd, old_t, old_d;
    @(negedge clk);
    tick = tk; req = rq; we = w; addr = a; wdata = d;
    @(posedge clk);
    ct = 0; cd = 0;
    old_t = p_t; old_d = p_d;
    wt = rq && w && a == 8'h14;
    wd = rq && w && a == 8'h10;
    if (p_t && tk) begin if (c_t + 1 == COMMIT) ct = 1; else c_t++; end
    if (p_d && tk) begin if (c_d + 1 == COMMIT) cd = 1; else c_d++; end
    carry = tk && !ct && m_hr >= 23 && m_min >= 59 && m_sec >= 59;
    if (ct) begin
      m_sec = int'(s_t[5:0]); m_min = int'(s_t[13:8]); m_hr = int'(s_t[20:16]);
    end else if (tk) begin
      if (m_sec >= 59) begin
        m_sec = 0;
        if (m_min >= 59) begin m_min = 0; m_hr = (m_hr >= 23) ? 0 : m_hr + 1; end
        else m_min++;
      end else m_sec++;
    end
    if (cd) begin
      m_day = int'(s_d[4:0]); m_mon = int'(s_d[11:8]);
      m_yr = int'(s_d[21:16]); m_leap = s_d[22];
    end else if (carry) begin
      if (m_day >= days_in(m_mon, m_leap)) begin
        m_day = 1;
        if (m_mon >= 12) begin
          m_mon = 1; m_yr = (m_yr + 1) % 64; m_leap = ((m_yr + 1970) % 4) == 0;
        end else m_mon++;
      end else m_day++;
    end
    if (ct) p_t = 0;
    if (cd) p_d = 0;
    if (wt && !old_t) begin p_t = 1; c_t = 0; s_t = d; end
    if (wd && !old_d) begin p_d = 1; c_d = 0; s_d = d; end
  endtask

  task automatic check_reg(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    tick = 0; req = 0; we = 0; addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, rdata, exp);
    end
  endtask

  task automatic check_all(string tag);
    check_reg(8'h14, mk_time(m_hr, m_min, m_sec), tag);
    check_reg(8'h10, mk_date(m_yr, m_mon, m_day, m_leap), tag);
    check_reg(8'h00, (32'(p_t) << 8) | (32'(p_d) << 7), tag);
  endtask

  task automatic put(logic [7:0] a, logic [31:0] d);
    step(0, 1, 1, a, d);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00, '0);
  endtask

  task automatic load_both(logic [31:0] t, logic [31:0] d);
    put(8'h14, t);
    put(8'h10, d);
    ticks(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R1");

    // R4 / R10 / R5: pending flag, live advance, commit on second tick
    put(8'h14, mk_time(23, 59, 58));
    check_all("R4");
    ticks(1);
    check_all("R10");
    ticks(1);
    check_all("R5");
    check_all("R2");

    // R5: a tick in the write cycle is not counted
    step(1, 1, 1, 8'h10, mk_date(5, 6, 7, 0));
    ticks(1);
    check_all("R5");
    ticks(1);
    check_all("R3");

    // R6: second write while pending and write in commit cycle are dropped
    put(8'h14, mk_time(1, 2, 3));
    put(8'h14, mk_time(4, 5, 6));
    ticks(1);
    step(1, 1, 1, 8'h14, mk_time(7, 8, 9));
    check_all("R6");

    // R11: status and unmapped writes
    put(8'h00, 32'hFFFF_FFFF);
    put(8'h20, 32'hFFFF_FFFF);
    check_all("R11");

    // R7
    load_both(mk_time(10, 59, 59), mk_date(3, 3, 3, 0));
    ticks(1);
    check_all("R7");

    // R8: month lengths and February
    load_both(mk_time(23, 59, 59), mk_date(2, 2, 28, 1));
    ticks(1);
    check_all("R8");
    load_both(mk_time(23, 59, 59), mk_date(2, 2, 29, 1));
    ticks(1);
    check_all("R8");
    load_both(mk_time(23, 59, 59), mk_date(3, 2, 28, 0));
    ticks(1);
    check_all("R8");
    load_both(mk_time(23, 59, 59), mk_date(3, 4, 30, 0));
    ticks(1);
    check_all("R8");

    // R9: year wrap and leap recompute
    load_both(mk_time(23, 59, 59), mk_date(63, 12, 31, 0));
    ticks(1);
    check_all("R9");
    load_both(mk_time(23, 59, 59), mk_date(1, 12, 31, 0));
    ticks(1);
    check_all("R9");

    // R10: date commit collides with day carry
    put(8'h14, mk_time(23, 59, 58));
    ticks(2);
    put(8'h10, mk_date(9, 9, 9, 0));
    ticks(1);
    ticks(1);
    check_all("R10");

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [31:0] d;
      r = int'($urandom % 8);
      if ($urandom % 2 == 0)
        d = mk_time(21 + int'($urandom % 3), 57 + int'($urandom % 3), 57 + int'($urandom % 3));
      else
        d = mk_time(int'($urandom % 24), int'($urandom % 60), int'($urandom % 60));
      case (r)
        0: step($urandom % 2 == 1, 1, 1, 8'h14, d);
        1: step($urandom % 2 == 1, 1, 1, 8'h10,
                mk_date(int'($urandom % 64), 1 + int'($urandom % 12), 27 + int'($urandom % 2),
                        $urandom % 2 == 1));
        2: step($urandom % 2 == 1, 1, 1, 8'h00, $urandom);
        default: step($urandom % 4 != 0, 0, 0, 8'h00, '0);
      endcase
      if (i % 3 == 0) check_all("R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule